// File: doc/BRIEF.md
# Selectable clock ratio enable generator

This block runs from one fast reference clock and produces four synchronous clock-enable strobes. They stand for the processor rate, its half rate, a double-base rate and the base (1x) rate of a processor clock tree. A mode input selects one of two ratio sets between the fastest strobe and the base strobe: 6:3:2:1 or 4:2:2:1. Downstream logic stays on the reference clock and qualifies its registers with the strobe for its rate. The outputs are enable strobes and never derived clocks.

All strobes are phase-aligned: every pulse of a slower strobe falls on a pulse of each faster one. All four strobes are high together on the cycle where the base strobe fires. A mode request is registered and takes effect only at that common alignment point. The base period in which the request arrives always completes at its old length, and the next period runs at the new length. A status output reports the scheme in force, which can differ from the one requested.

Top module: `clk_ratio_en_gen`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, mode_act_o is 0 (6:3:2:1) and all four enables are high.
- R2: en_fast_o is high on every cycle.
- R3: en_half_o alternates high and low on consecutive cycles in both schemes, and is high at every alignment point.
- R4: en_dbl_o is high once every 3 cycles in scheme 0 and once every 2 cycles in scheme 1, counted from the alignment point.
- R5: en_base_o is high once every 6 cycles in scheme 0 and once every 4 cycles in scheme 1.
- R6: Whenever en_base_o is high, en_half_o and en_dbl_o are high in the same cycle.
- R7: mode_req_i (0 = 6:3:2:1, 1 = 4:2:2:1) is registered on every clock. mode_act_o uses the same encoding. mode_act_o takes the registered request only on the clock edge that ends a base period. It therefore changes only on a cycle where en_base_o is high.
- R8: A period that spans a scheme switch is never shortened or stretched. The base interval ending at the switch has the old scheme's length, and the next interval has the new scheme's length.
- R9: A request held for a time that does not cover the second-to-last cycle of a base period has no effect. mode_act_o stays unchanged and the base spacing keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock (processor rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_req_i | input | 1 | Requested scheme: 0 = 6:3:2:1, 1 = 4:2:2:1 |
| en_fast_o | output | 1 | Processor-rate enable, constantly high |
| en_half_o | output | 1 | Half-rate enable |
| en_dbl_o | output | 1 | Twice-base-rate enable |
| en_base_o | output | 1 | Base (1x) rate enable |
| mode_act_o | output | 1 | Scheme currently in force |

## Verification
The hardest situation to reach from the ports is a request that changes close to a period boundary. A request seen in the second-to-last cycle must switch the scheme, and a request withdrawn one cycle earlier must not. The stimulus reaches both by stepping the base period cycle by cycle and toggling the request in chosen phases. It then measures the base interval on each side of the boundary. A table of request segments with awkward lengths (1, 2, 5 and 9 cycles) also drives the request across every phase of both periods.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  typedef enum logic {
    SCHEME_6321 = 1'b0,
    SCHEME_4221 = 1'b1
  } scheme_e;

  localparam int unsigned NUM_EN = 4;
  localparam int unsigned EN_FAST = 0;
  localparam int unsigned EN_HALF = 1;
  localparam int unsigned EN_DBL  = 2;
  localparam int unsigned EN_BASE = 3;
endpackage

// File: rtl/ratio_mode_ctl.sv
module ratio_mode_ctl
  import clk_ratio_pkg::*;
#(
  parameter int unsigned RATIO_A = 6,
  parameter int unsigned RATIO_B = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wrap_i,
  output scheme_e          scheme_o,
  output logic [CNT_W-1:0] per_m1_o,
  output logic [CNT_W-1:0] sub_m1_o
);
  localparam logic [CNT_W-1:0] PER_A_M1 = CNT_W'(RATIO_A - 1);
  localparam logic [CNT_W-1:0] PER_B_M1 = CNT_W'(RATIO_B - 1);
  localparam logic [CNT_W-1:0] SUB_A_M1 = CNT_W'(RATIO_A / 2 - 1);
  localparam logic [CNT_W-1:0] SUB_B_M1 = CNT_W'(RATIO_B / 2 - 1);

  logic    req_q;
  scheme_e act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      act_q <= SCHEME_6321;
    end else begin
      req_q <= req_i;
      // switch only at the period boundary
      if (wrap_i) act_q <= scheme_e'(req_q);
    end
  end

  always_comb begin
    if (act_q == SCHEME_6321) begin
      per_m1_o = PER_A_M1;
      sub_m1_o = SUB_A_M1;
    end else begin
      per_m1_o = PER_B_M1;
      sub_m1_o = SUB_B_M1;
    end
  end

  assign scheme_o = act_q;
endmodule

// File: rtl/ratio_phase_cnt.sv
module ratio_phase_cnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] per_m1_i,
  input  logic [CNT_W-1:0] sub_m1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] sub_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, sub_q;
  logic             wrap, sub_wrap;

  assign wrap     = (cnt_q == per_m1_i);
  assign sub_wrap = (sub_q == sub_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      // sub-period restarts with the main period to keep alignment
      sub_q <= (wrap || sub_wrap) ? '0 : sub_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign sub_o  = sub_q;
  assign wrap_o = wrap;
endmodule

// File: rtl/ratio_strobe_dec.sv
module ratio_strobe_dec
  import clk_ratio_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  sub_i,
  output logic [NUM_EN-1:0] en_o
);
  for (genvar i = 0; i < NUM_EN; i++) begin : g_en
    if (i == EN_FAST) begin : g_fast
      assign en_o[i] = 1'b1;
    end else if (i == EN_HALF) begin : g_half
      // periods are even, so the low count bit gives the half rate
      assign en_o[i] = ~cnt_i[0];
    end else if (i == EN_DBL) begin : g_dbl
      assign en_o[i] = (sub_i == '0);
    end else begin : g_base
      assign en_o[i] = (cnt_i == '0);
    end
  end
endmodule

// File: rtl/clk_ratio_en_gen.sv
module clk_ratio_en_gen
  import clk_ratio_pkg::*;
#(
  parameter int unsigned RATIO_A = 6,
  parameter int unsigned RATIO_B = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_req_i,
  output logic en_fast_o,
  output logic en_half_o,
  output logic en_dbl_o,
  output logic en_base_o,
  output logic mode_act_o
);
  localparam int unsigned RATIO_MAX = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
  localparam int unsigned CNT_W     = $clog2(RATIO_MAX);

  scheme_e           scheme;
  logic [CNT_W-1:0]  per_m1, sub_m1, cnt, sub;
  logic              wrap;
  logic [NUM_EN-1:0] en;

  ratio_mode_ctl #(
    .RATIO_A(RATIO_A),
    .RATIO_B(RATIO_B),
    .CNT_W  (CNT_W)
  ) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (mode_req_i),
    .wrap_i  (wrap),
    .scheme_o(scheme),
    .per_m1_o(per_m1),
    .sub_m1_o(sub_m1)
  );

  ratio_phase_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .per_m1_i(per_m1),
    .sub_m1_i(sub_m1),
    .cnt_o   (cnt),
    .sub_o   (sub),
    .wrap_o  (wrap)
  );

  ratio_strobe_dec #(
    .CNT_W(CNT_W)
  ) u_dec (
    .cnt_i(cnt),
    .sub_i(sub),
    .en_o (en)
  );

  assign en_fast_o  = en[EN_FAST];
  assign en_half_o  = en[EN_HALF];
  assign en_dbl_o   = en[EN_DBL];
  assign en_base_o  = en[EN_BASE];
  assign mode_act_o = scheme;
endmodule

// File: rtl/clk_ratio_en_gen_chk.sv
module clk_ratio_en_gen_chk #(
  parameter int unsigned RATIO_A = 6,
  parameter int unsigned RATIO_B = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_fast_o,
  input logic en_half_o,
  input logic en_dbl_o,
  input logic en_base_o,
  input logic mode_act_o
);
  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (en_base_o) begin
      gap_q  <= 8'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 8'hff) begin
      gap_q <= gap_q + 8'd1;
    end
  end

  // R2
  fast_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fast_o);

  // R6
  base_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_base_o |-> (en_half_o && en_dbl_o));

  // R3
  half_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_half_o |=> !en_half_o);

  // R3
  half_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_half_o |=> en_half_o);

  // R4
  dbl_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_dbl_o |=> !en_dbl_o);

  // R7
  switch_at_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_act_o) |-> en_base_o);

  // R5 R8
  base_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && en_base_o) |->
      (gap_q == ($past(mode_act_o) ? 8'(RATIO_B) : 8'(RATIO_A))));
endmodule

bind clk_ratio_en_gen clk_ratio_en_gen_chk #(
  .RATIO_A(RATIO_A),
  .RATIO_B(RATIO_B)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_fast_o (en_fast_o),
  .en_half_o (en_half_o),
  .en_dbl_o  (en_dbl_o),
  .en_base_o (en_base_o),
  .mode_act_o(mode_act_o)
);

// File: tb/clk_ratio_en_gen_bench.sv
`timescale 1ns/1ps
module clk_ratio_en_gen_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_req_i = 1'b0;
  logic en_fast_o, en_half_o, en_dbl_o, en_base_o, mode_act_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0;
  int m_act = 0;
  int m_req_q = 0;

  always #4 clk_i = ~clk_i;

  clk_ratio_en_gen u_clk_ratio_en_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_req_i(mode_req_i),
    .en_fast_o (en_fast_o),
    .en_half_o (en_half_o),
    .en_dbl_o  (en_dbl_o),
    .en_base_o (en_base_o),
    .mode_act_o(mode_act_o)
  );

  // stimulus segments: {request, cycles}
  localparam int NVEC = 12;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 8'd20}, {1'b1, 8'd9}, {1'b0, 8'd5}, {1'b1, 8'd30},
    {1'b0, 8'd1},  {1'b1, 8'd2}, {1'b0, 8'd13}, {1'b1, 8'd1},
    {1'b0, 8'd7},  {1'b1, 8'd17}, {1'b0, 8'd2}, {1'b0, 8'd24}
  };

  function automatic int per(input int a);
    return a ? 4 : 6;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 en_fast_o", en_fast_o, 1);
    chk("R3 en_half_o", en_half_o, int'(m_cnt % 2 == 0));
    chk("R4 en_dbl_o", en_dbl_o, int'(m_cnt % (per(m_act) / 2) == 0));
    chk("R5 en_base_o", en_base_o, int'(m_cnt == 0));
    chk("R7 mode_act_o", mode_act_o, m_act);
    if (en_base_o) chk("R6 alignment", int'(en_half_o && en_dbl_o), 1);
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step(input logic req);
    mode_req_i = req;
    @(posedge clk_i);
    if (m_cnt == per(m_act) - 1) begin
      m_cnt = 0;
      m_act = m_req_q;
    end else begin
      m_cnt++;
    end
    m_req_q = int'(mode_req_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic run_until_base(input logic req, output int n);
    n = 0;
    do begin
      step(req);
      n++;
    end while (!en_base_o && n < 20);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    mode_req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    // R1 state held in reset
    chk("R1 act in reset", mode_act_o, 0);
    chk("R1 enables in reset",
        int'({en_fast_o, en_half_o, en_dbl_o, en_base_o}), 15);
    rst_ni = 1'b1;
    m_cnt = 0; m_act = 0; m_req_q = 0;
    #1;
    chk("R1 act after release", mode_act_o, 0);
    chk("R1 enables after release",
        int'({en_fast_o, en_half_o, en_dbl_o, en_base_o}), 15);
  endtask

  initial begin
    int n;
    do_reset();

    foreach (VEC[v]) begin
      for (int c = 0; c < int'(VEC[v][7:0]); c++) step(VEC[v][8]);
    end

    // R1 reset in the middle of a scheme 1 period
    for (int c = 0; c < 10; c++) step(1'b1);
    do_reset();

    // R8 interval lengths across a switch
    run_until_base(1'b0, n);
    run_until_base(1'b0, n);
    run_until_base(1'b0, n);
    chk("R8 settle in scheme 0", mode_act_o, 0);
    run_until_base(1'b1, n);
    chk("R8 old interval kept", n, 6);
    chk("R7 switch to scheme 1", mode_act_o, 1);
    run_until_base(1'b1, n);
    chk("R8 new interval", n, 4);
    run_until_base(1'b0, n);
    chk("R8 old interval back", n, 4);
    chk("R7 switch to scheme 0", mode_act_o, 0);
    run_until_base(1'b0, n);
    chk("R8 new interval back", n, 6);

    // R9 request pulse in phase 2 of a scheme 0 period: ignored
    step(1'b0);
    step(1'b0);
    step(1'b1);
    step(1'b0);
    run_until_base(1'b0, n);
    chk("R9 act unchanged", mode_act_o, 0);
    run_until_base(1'b0, n);
    chk("R9 interval unchanged", n, 6);

    // R7 request pulse in the second-to-last cycle: taken
    step(1'b0);
    step(1'b0);
    step(1'b0);
    step(1'b0);
    step(1'b1);
    step(1'b0);
    chk("R7 late request applied", mode_act_o, 1);
    chk("R7 boundary strobe", en_base_o, 1);
    run_until_base(1'b0, n);
    chk("R5 scheme 1 interval", n, 4);
    chk("R7 return to scheme 0", mode_act_o, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule